// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is a memory-mapped SPI host that runs one flash-style command each time software starts it. A command always begins with an opcode byte. A programmed number of outgoing bytes follows, taken from a 70-byte byte buffer. A programmed number of incoming bytes comes last. The incoming bytes are written back into the same buffer, directly behind the outgoing ones. Only one direction carries data at any time. While bytes are being received, MOSI is held low, and MISO is ignored while bytes are being sent.

Software drives the block through a 32-bit register port with byte enables. Each register can be reached as a single byte or as part of a word. The port is a plain register bus, not a stream: a write takes effect on the clock edge where `bus_wr` is high, and read data is returned in the same cycle for the address presented. There is no back-pressure. Software polls the busy flag and must wait for it to clear before it programs the next command. The serial clock runs at one quarter of the system clock in SPI mode 0, most significant bit first. One of four active-low selects frames each command.

The buffer pointer is shared by both directions and is not reset after a command. A command therefore starts where the previous one stopped, unless software clears the pointer first. The pointer wraps at the end of the buffer.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every chip select is high, `spi_sclk` is low, the busy bit reads 0, and the opcode register, count registers and buffer all read 0.
- R2: The registers are reached by byte lane. The select register is byte 0x1D (word 0x1C, bits 15:8) and reads back all 8 bits. The opcode is byte 0x45 (word 0x44, bits 15:8). The transmit count is byte 0x48 (word 0x48, bits 7:0). The receive count is byte 0x4B (word 0x48, bits 31:24).
- R3: A command starts on a write of 1 to bit 7 of byte 0x47 (word bit 31 at 0x44), or on a write of 1 to bit 16 of word 0x00. Bit 31 of word 0x00 and of word 0x4C then reads 1 for exactly 8+32*N cycles, where N = 1 + tx + rx.
- R4: `spi_sclk` has a period of 4 system clocks, high for 2 of them, and is low whenever the block is idle. MOSI changes only while `spi_sclk` is low.
- R5: The bytes on MOSI are the opcode, then tx bytes read from the buffer starting at the pointer, then rx bytes of 0x00. All bytes are sent MSB first.
- R6: MISO is sampled on each rising `spi_sclk` edge during the receive bytes. Each received byte is stored at the pointer position that follows the transmit bytes.
- R7: Bits 1:0 of the select register choose which `spi_cs_n` line goes low, and that line is low exactly while busy. The other select lines stay high.
- R8: The pointer advances by tx+rx for each command and wraps from 69 to 0. Writing 1 to bit 20 of word 0x00 resets the pointer to 0.
- R9: If a single write carries both the pointer reset (bit 20) and the start bit (bit 16), the reset takes effect first and the command begins at offset 0.
- R10: While busy, every register write is ignored. This covers the start bits, the buffer, the counts, the opcode and the select register.
- R11: A command with tx = rx = 0 sends only the opcode and stays busy for 40 cycles.
- R12: Buffer byte offset k is at address 0x80+k for k < 70. Writes to any higher address are ignored, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_addr | input | 8 | Byte address; bits 7:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_miso | input | 1 | Serial data from the device |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The pointer reset and the command start can both be requested in a single control-word write. The bench issues one word write with both bits set after the pointer has been left at a non-zero offset. It then checks that the first transmitted data byte comes from buffer offset 0, and that the following command continues from the new pointer. A second same-cycle case is a write that arrives while a command runs. The bench injects a start, a buffer write and a count write in the middle of a command. It then expects the busy window, the serial bytes and the read-back registers to show none of them.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int LANES  = 4;

  localparam logic [ADDR_W-3:0] W_CTRL   = 6'h00;
  localparam logic [ADDR_W-3:0] W_CSEL   = 6'h07;
  localparam logic [ADDR_W-3:0] W_OPTRIG = 6'h11;
  localparam logic [ADDR_W-3:0] W_COUNT  = 6'h12;
  localparam logic [ADDR_W-3:0] W_STAT   = 6'h13;
  localparam logic [ADDR_W-1:0] BUF_BASE = 8'h80;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_SHIFT,
    SQ_HOLD
  } seq_state_t;
endpackage

// File: rtl/spi_byte_buf.sv
module spi_byte_buf #(
  parameter int DEPTH = 70,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            bus_we,
  input  logic [LANES-1:0][PTR_W-1:0] bus_idx,
  input  logic [8*LANES-1:0]          bus_wdata,
  output logic [8*LANES-1:0]          bus_rdata,
  input  logic                        eng_we,
  input  logic [PTR_W-1:0]            eng_idx,
  input  logic [7:0]                  eng_wdata,
  output logic [7:0]                  eng_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (bus_we[l]) mem[bus_idx[l]] <= bus_wdata[8*l +: 8];
      if (eng_we) mem[eng_idx] <= eng_wdata;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign bus_rdata[8*l +: 8] = (int'(bus_idx[l]) < DEPTH) ? mem[bus_idx[l]] : 8'h00;
  end

  assign eng_rdata = mem[eng_idx];
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 70,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr_ptr,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             miso,
  input  logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic [PTR_W-1:0] ptr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata
);
  seq_state_t       st;
  logic [1:0]       q;
  logic [2:0]       bitn;
  logic [7:0]       shreg, rxsh;
  logic [CNT_W-1:0] tx_left, rx_left;
  logic             cur_rx;
  logic [PTR_W-1:0] ptr_next;

  assign ptr_next  = (int'(ptr) == DEPTH - 1) ? '0 : ptr + 1'b1;
  assign busy      = (st != SQ_IDLE);
  assign sclk      = (st == SQ_SHIFT) && q[1];
  assign mosi      = (st == SQ_SHIFT) && shreg[7];
  assign buf_we    = (st == SQ_SHIFT) && (q == 2'd3) && (bitn == 3'd7) && cur_rx;
  assign buf_wdata = rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      q       <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rxsh    <= '0;
      tx_left <= '0;
      rx_left <= '0;
      cur_rx  <= 1'b0;
      ptr     <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (clr_ptr) ptr <= '0;
          if (start) begin
            st      <= SQ_SETUP;
            q       <= '0;
            tx_left <= tx_cnt;
            rx_left <= rx_cnt;
          end
        end
        SQ_SETUP: begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            st     <= SQ_SHIFT;
            shreg  <= opcode;
            cur_rx <= 1'b0;
            bitn   <= '0;
          end
        end
        SQ_SHIFT: begin
          q <= q + 2'd1;
          if (q == 2'd1) rxsh <= {rxsh[6:0], miso};
          if (q == 2'd3) begin
            if (bitn != 3'd7) begin
              bitn  <= bitn + 3'd1;
              shreg <= {shreg[6:0], 1'b0};
            end else begin
              bitn <= '0;
              if (cur_rx) ptr <= ptr_next;
              if (tx_left != '0) begin
                shreg   <= buf_rdata;
                ptr     <= ptr_next;
                tx_left <= tx_left - 1'b1;
                cur_rx  <= 1'b0;
              end else if (rx_left != '0) begin
                shreg   <= '0;
                rx_left <= rx_left - 1'b1;
                cur_rx  <= 1'b1;
              end else begin
                st <= SQ_HOLD;
              end
            end
          end
        end
        SQ_HOLD: begin
          q <= q + 2'd1;
          if (q == 2'd3) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 70,
  parameter int NUM_CS    = 4,
  localparam int PTR_W    = $clog2(BUF_BYTES),
  localparam int CS_SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              spi_miso,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam logic [ADDR_W-1:0] BUF_END = ADDR_W'(int'(BUF_BASE) + BUF_BYTES);

  logic [ADDR_W-3:0] bus_word;
  logic              seq_busy, wr_ok, start, clr_ptr;
  logic [7:0]        csel_q, opcode_q;
  logic [CNT_W-1:0]  tx_q, rx_q;

  logic [LANES-1:0]            lane_in_buf, lane_we;
  logic [LANES-1:0][PTR_W-1:0] lane_idx;
  logic [8*LANES-1:0]          buf_bus_rdata;
  logic [PTR_W-1:0]            eng_ptr;
  logic                        eng_we;
  logic [7:0]                  eng_wdata, eng_rdata;

  assign bus_word = bus_addr[ADDR_W-1:2];
  assign wr_ok    = bus_wr && !seq_busy;
  assign start    = wr_ok && ((bus_word == W_CTRL && bus_be[2] && bus_wdata[16]) ||
                              (bus_word == W_OPTRIG && bus_be[3] && bus_wdata[31]));
  assign clr_ptr  = wr_ok && bus_word == W_CTRL && bus_be[2] && bus_wdata[20];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr      = {bus_word, 2'(l)};
    assign lane_in_buf[l] = (lane_addr >= BUF_BASE) && (lane_addr < BUF_END);
    assign lane_idx[l]    = PTR_W'(lane_addr - BUF_BASE);
    assign lane_we[l]     = wr_ok && bus_be[l] && lane_in_buf[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q   <= '0;
      opcode_q <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (wr_ok) begin
      if (bus_word == W_CSEL && bus_be[1])   csel_q   <= bus_wdata[15:8];
      if (bus_word == W_OPTRIG && bus_be[1]) opcode_q <= bus_wdata[15:8];
      if (bus_word == W_COUNT && bus_be[0])  tx_q     <= bus_wdata[7:0];
      if (bus_word == W_COUNT && bus_be[3])  rx_q     <= bus_wdata[31:24];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_word)
      W_CTRL, W_STAT: bus_rdata[31] = seq_busy;
      W_CSEL:         bus_rdata[15:8] = csel_q;
      W_OPTRIG:       bus_rdata[15:8] = opcode_q;
      W_COUNT: begin
        bus_rdata[7:0]   = tx_q;
        bus_rdata[31:24] = rx_q;
      end
      default: begin
        for (int l = 0; l < LANES; l++)
          if (lane_in_buf[l]) bus_rdata[8*l +: 8] = buf_bus_rdata[8*l +: 8];
      end
    endcase
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign spi_cs_n[c] = !(seq_busy && csel_q[CS_SEL_W-1:0] == CS_SEL_W'(c));
  end

  spi_byte_buf #(.DEPTH(BUF_BYTES), .LANES(LANES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (lane_we),
    .bus_idx   (lane_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (buf_bus_rdata),
    .eng_we    (eng_we),
    .eng_idx   (eng_ptr),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata)
  );

  spi_seq #(.DEPTH(BUF_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .clr_ptr   (clr_ptr),
    .opcode    (opcode_q),
    .tx_cnt    (tx_q),
    .rx_cnt    (rx_q),
    .miso      (spi_miso),
    .buf_rdata (eng_rdata),
    .busy      (seq_busy),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .ptr       (eng_ptr),
    .buf_we    (eng_we),
    .buf_wdata (eng_wdata)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n
);
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  p_sclk_high2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
  p_sclk_low2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |=> !sclk);
  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_cs_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) == (busy ? 1 : 0));
  p_cs_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (seq_busy),
  .start (start),
  .sclk  (spi_sclk),
  .mosi  (spi_mosi),
  .cs_n  (spi_cs_n)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int DEPTH = 70;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_miso = 1'b0;
  logic        spi_sclk, spi_mosi;
  logic [3:0]  spi_cs_n;

  always #(TCLK/2) clk = ~clk;

  spi_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n)
  );

  int checks = 0, failures = 0;
  int mon_checks = 0, mon_fail = 0;
  bit done = 1'b0;

  // behavioural reference state (written by the stimulus process)
  logic [7:0] m_mem [DEPTH];
  int         m_ptr = 0;
  logic [7:0] m_csel = '0, m_op = '0, m_tx = '0, m_rx = '0;
  int         s_cyc = -1000000, s_dur = 0;
  logic [7:0] resp_q[$];
  logic [7:0] exp_q[$];

  // monitor state (written by the monitor process)
  int         ncyc = 0;
  logic [7:0] cap_q[$];
  logic       prev_sclk = 1'b0, prev_csl = 1'b0, prev_mosi = 1'b0;
  int         kbit = 0, capbits = 0;
  logic [7:0] capbyte = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic resp_bit(input int k);
    if (k / 8 < resp_q.size()) return resp_q[k/8][7 - (k % 8)];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic       exp_busy;
      logic [3:0] exp_cs;
      logic       csl;
      ncyc++;
      exp_busy = (ncyc - s_cyc >= 1) && (ncyc - s_cyc <= s_dur);
      exp_cs = exp_busy ? ~(4'b0001 << m_csel[1:0]) : 4'hF;
      mon_checks++;
      if (spi_cs_n !== exp_cs) begin
        mon_fail++;
        $display("FAIL R7 cs_n at cycle %0d actual=%0h expected=%0h", ncyc, spi_cs_n, exp_cs);
      end
      if (!exp_busy && spi_sclk !== 1'b0) begin
        mon_fail++;
        $display("FAIL R4 sclk while idle actual=%0b expected=0", spi_sclk);
      end
      if (prev_sclk && spi_sclk && spi_mosi !== prev_mosi) begin
        mon_fail++;
        $display("FAIL R4 mosi moved while sclk high actual=%0b expected=%0b", spi_mosi, prev_mosi);
      end
      csl = (spi_cs_n != 4'hF);
      if (csl && !prev_csl) begin
        cap_q.delete();
        kbit = 0; capbits = 0;
        spi_miso <= resp_bit(0);
      end
      if (spi_sclk && !prev_sclk) begin
        capbyte = {capbyte[6:0], spi_mosi};
        capbits++;
        if (capbits % 8 == 0) cap_q.push_back(capbyte);
      end
      if (!spi_sclk && prev_sclk) begin
        kbit++;
        spi_miso <= resp_bit(kbit);
      end
      prev_sclk = spi_sclk; prev_csl = csl; prev_mosi = spi_mosi;
      if (ncyc > 150000) begin
        mon_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", ncyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
        $finish;
      end
    end
  end

  function automatic bit model_busy();
    return (ncyc - s_cyc) < s_dur;
  endfunction

  task automatic apply_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bit go = 1'b0;
    if (model_busy()) return;   // R10: writes while busy have no effect
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        int ba;
        logic [7:0] v;
        ba = {a[7:2], 2'(l)};
        v  = d[8*l +: 8];
        if (ba == 8'h02) begin
          if (v[4]) m_ptr = 0;
          if (v[0]) go = 1'b1;
        end
        if (ba == 8'h1D) m_csel = v;
        if (ba == 8'h45) m_op = v;
        if (ba == 8'h47 && v[7]) go = 1'b1;
        if (ba == 8'h48) m_tx = v;
        if (ba == 8'h4B) m_rx = v;
        if (ba >= 8'h80 && ba - 8'h80 < DEPTH) m_mem[ba - 8'h80] = v;
      end
    end
    if (go) begin
      exp_q.delete();
      exp_q.push_back(m_op);
      for (int i = 0; i < m_tx; i++) exp_q.push_back(m_mem[(m_ptr + i) % DEPTH]);
      for (int j = 0; j < m_rx; j++) exp_q.push_back(8'h00);
      for (int j = 0; j < m_rx; j++)
        m_mem[(m_ptr + m_tx + j) % DEPTH] = resp_q[1 + m_tx + j];
      m_ptr = (m_ptr + m_tx + m_rx) % DEPTH;
      s_cyc = ncyc;
      s_dur = 8 + 32 * (1 + m_tx + m_rx);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    apply_write(a, be, d);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic check_buf(input string req);
    logic [31:0] d;
    for (int w = 0; w < 18; w++) begin
      rd(8'(8'h80 + 4 * w), d);
      for (int l = 0; l < 4; l++) begin
        int k;
        logic [7:0] e;
        k = 4 * w + l;
        e = (k < DEPTH) ? m_mem[k] : 8'h00;
        chk(d[8*l +: 8] == e, (k < DEPTH) ? req : "R12", $sformatf("buffer byte %0d", k), d[8*l +: 8], e);
      end
    end
  endtask

  // how: 0 start bit in byte 0x47, 1 start bit 16 of word 0, 2 reset+start in one write,
  //      3 as 0 with writes injected while busy
  task automatic do_cmd(input int how);
    logic [31:0] d;
    int n, cnt, it;
    logic [7:0] poll_a;
    n = 1 + m_tx + m_rx;
    resp_q.delete();
    for (int i = 0; i < n; i++) resp_q.push_back(8'($urandom));
    case (how)
      1:       wr(8'h00, 4'b0100, 32'h0001_0000);
      2:       wr(8'h00, 4'b0100, 32'h0011_0000);
      default: wr(8'h44, 4'b1000, 32'h8000_0000);
    endcase
    poll_a = (how == 1) ? 8'h00 : 8'h4C;
    cnt = 0; it = 0;
    while (cnt < 100000) begin
      if (how == 3 && it == 2) begin wr(8'h44, 4'b1000, 32'h8000_0000); cnt++; end
      else if (how == 3 && it == 3) begin wr(8'h80, 4'b0001, 32'h0000_005A); cnt++; end
      else if (how == 3 && it == 4) begin wr(8'h48, 4'b0001, 32'h0000_0033); cnt++; end
      else begin
        rd(poll_a, d);
        if (!d[31]) break;
        cnt++;
      end
      it++;
    end
    chk(cnt == 8 + 32 * n, "R3", "busy cycles", cnt, 8 + 32 * n);
    repeat (3) @(negedge clk);
    chk(cap_q.size() == n, "R5", "bytes on MOSI", cap_q.size(), n);
    for (int i = 0; i < n && i < cap_q.size(); i++)
      chk(cap_q[i] == exp_q[i], (i <= m_tx) ? "R5" : "R6",
          $sformatf("MOSI byte %0d", i), cap_q[i], exp_q[i]);
    check_buf("R6");
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d);  chk(d == 32'h0, "R1", "control word", d, 0);
    rd(8'h4C, d);  chk(d == 32'h0, "R1", "status word", d, 0);
    rd(8'h44, d);  chk(d == 32'h0, "R1", "opcode word", d, 0);
    rd(8'h48, d);  chk(d == 32'h0, "R1", "count word", d, 0);
    chk(spi_cs_n == 4'hF, "R1", "cs_n", spi_cs_n, 4'hF);
    chk(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
    check_buf("R1");

    // R2 register lanes
    wr(8'h1C, 4'b0010, 32'h0000_A600);
    rd(8'h1C, d);  chk(d == 32'h0000_A600, "R2", "select register", d, 32'h0000_A600);
    wr(8'h48, 4'b1001, 32'h0500_0003);
    rd(8'h48, d);  chk(d == 32'h0500_0003, "R2", "count word", d, 32'h0500_0003);
    wr(8'h44, 4'b0010, 32'h0000_9F00);
    rd(8'h44, d);  chk(d == 32'h0000_9F00, "R2", "opcode word", d, 32'h0000_9F00);

    // R12 buffer window, including lanes past the end
    for (int w = 0; w < 18; w++) begin
      logic [31:0] pat;
      for (int l = 0; l < 4; l++) pat[8*l +: 8] = 8'((4 * w + l) * 7 + 3);
      wr(8'(8'h80 + 4 * w), 4'hF, pat);
    end
    wr(8'hC8, 4'hF, 32'hFFFF_FFFF);
    check_buf("R12");

    // R3 R5 R6 R7: reset pointer, then start via byte 0x47, select 2
    wr(8'h00, 4'b0100, 32'h0010_0000);
    do_cmd(0);

    // R8 continuation from pointer 8, start via bit 16, select 1 with upper bits set
    wr(8'h1C, 4'b0010, 32'h0000_F100);
    wr(8'h48, 4'b1001, 32'h0200_0002);
    wr(8'h44, 4'b0010, 32'h0000_3B00);
    do_cmd(1);

    // R9 reset and start in the same write
    wr(8'h48, 4'b1001, 32'h0000_0042);
    do_cmd(2);
    chk(cap_q.size() > 1 && cap_q[1] == m_mem[0], "R9", "first data byte from offset 0",
        (cap_q.size() > 1) ? cap_q[1] : 0, m_mem[0]);

    // R8 wrap: pointer at 66, 2 out + 4 in reaches offsets 68,69,0,1
    wr(8'h1C, 4'b0010, 32'h0000_0300);
    wr(8'h48, 4'b1001, 32'h0400_0002);
    do_cmd(0);
    chk(m_ptr == 2, "R8", "model pointer after wrap", m_ptr, 2);

    // R11 opcode only
    wr(8'h48, 4'b1001, 32'h0000_0000);
    do_cmd(0);
    chk(cap_q.size() == 1, "R11", "opcode-only frame length", cap_q.size(), 1);

    // R10 writes during busy are ignored
    wr(8'h48, 4'b1001, 32'h0100_0001);
    do_cmd(3);
    rd(8'h48, d);  chk(d == 32'h0100_0001, "R10", "count word after busy write", d, 32'h0100_0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
    $finish;
  end
endmodule